// File: doc/BRIEF.md
# Bit-Serial Memory Access Requester

This block is the initiating end of a one-bit request link that a debug controller uses to read and write system memory. A command comes in over a parallel valid/ready handshake. It carries a direction flag, a 40-bit physical address and, for writes, a 64-bit data word. The block packs the direction and address into a 64-bit header and shifts it onto a single data wire, one bit per clock. For a write, the data word follows straight after the header.

After sending, the block waits for the far end. A write finishes when the far end returns a single acknowledge pulse. A read finishes once the far end has returned a pulse followed by 64 serial bits, which the block assembles into a parallel word. Either way, the result leaves on a one-cycle done strobe. A per-command timeout limit stops a wait that never ends and marks the command as failed.

Top module: `bsr_requester`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the cycle after `done` has been high.
- R2: The header word is {opcode[7:0], sixteen zero bits, address[39:0]}. Its top byte is 0x82 for a write (`cmd_write`=1) and 0x81 for a read (`cmd_write`=0).
- R3: Each word goes out on `link_data` over 64 consecutive cycles, least significant bit first. Bit 0 of the header is driven in the first cycle after the accepting edge.
- R4: `link_vld` is high for exactly one cycle per word, the cycle that carries that word's bit 0, and low for the other 63 bits.
- R5: A write sends the header and then `cmd_wdata`, 128 cycles back to back with two `link_vld` pulses. A read sends the 64-cycle header alone.
- R6: Outside the send cycles, `link_data` and `link_vld` are held low.
- R7: A write ends on the first cycle in the wait phase where `resp_vld` is high. `resp_data` is ignored at that point and at every other point of a write, and `rd_data` reads zero at done.
- R8: For a read, after the `resp_vld` pulse the block samples `resp_data` on the next 64 clocks, LSB first, and presents the word on `rd_data` at done.
- R9: `done` is high for one cycle. That cycle comes right after the edge that sampled a write acknowledge, the last read bit, or a timeout.
- R10: `tmo_limit` is captured when a command is accepted. A value L>0 lets the block wait L cycles. If `resp_vld` has not been seen by then, `done` rises L cycles after the first wait cycle, with `done_err`=1 and `rd_data`=0. L=0 waits without limit.
- R11: The address goes into the header unchanged, including its three low bits, which are not checked for alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 40 | Physical address |
| cmd_wdata | input | 64 | Write data |
| tmo_limit | input | 16 | Wait limit in cycles, 0 = none |
| link_vld | output | 1 | Word-start marker on the request link |
| link_data | output | 1 | Serial request bit |
| resp_vld | input | 1 | Acknowledge / reply-start pulse from the target |
| resp_data | input | 1 | Serial reply bit |
| done | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | Finished by timeout |
| rd_data | output | 64 | Read result, valid with done |

## Verification
A wrong bit counter or a lost pending-word flag shows at once on the link. The second `link_vld` pulse moves or disappears, or the header runs past 64 cycles, so it is caught within one word time. A phase error after the send shows as a misplaced `done`: too early, too late, or never. Each response is timed to the cycle, and the latency from the acknowledge or the last bit to `done`, or from wait start to a timeout, is checked exactly. A reply shifted the wrong way or off by one clock shows as a reversed or rotated `rd_data` at the done strobe.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_RECV = 3'd3,
    ST_DONE = 3'd4
  } bsr_state_e;

  // True when a count has reached the final index of a span of len positions.
  function automatic logic at_last(input logic [15:0] cnt, input logic [15:0] len);
    return (len != 16'd0) && (cnt == len - 16'd1);
  endfunction

  // Request header: opcode on top, zero padding, address at the bottom.
  function automatic logic [63:0] pack_header(input logic [7:0] op, input logic [39:0] addr);
    return {op, 16'h0000, addr};
  endfunction

endpackage

// File: rtl/bsr_tx_shifter.sv
module bsr_tx_shifter #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] first_word,
  input  logic [WORD_W-1:0] second_word,
  input  logic              two_words,
  output logic              ser_vld,
  output logic              ser_bit,
  output logic              active,
  output logic              last_bit
);
  import bsr_pkg::*;

  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] next_q;
  logic              pend_q;
  logic [CNT_W-1:0]  bit_q;
  logic              word_end;

  assign word_end = active && at_last(16'(bit_q), 16'(WORD_W));
  assign last_bit = word_end && !pend_q;
  assign ser_vld  = active && (bit_q == '0);
  assign ser_bit  = active && shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      next_q  <= '0;
      pend_q  <= 1'b0;
      bit_q   <= '0;
      active  <= 1'b0;
    end else if (load) begin
      shreg_q <= first_word;
      next_q  <= second_word;
      pend_q  <= two_words;
      bit_q   <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (word_end) begin
        bit_q <= '0;
        if (pend_q) begin
          shreg_q <= next_q;
          pend_q  <= 1'b0;
        end else begin
          shreg_q <= '0;
          active  <= 1'b0;
        end
      end else begin
        bit_q   <= bit_q + 1'b1;
        shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/bsr_rx_deser.sv
module bsr_rx_deser #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              last_bit
);
  import bsr_pkg::*;

  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0] cnt_q;

  assign last_bit = shift_en && at_last(16'(cnt_q), 16'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      word  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      word  <= {bit_in, word[WORD_W-1:1]};
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bsr_wait_timer.sv
module bsr_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TMO_W-1:0] limit,
  input  logic             run,
  output logic             expire
);
  import bsr_pkg::*;

  logic [TMO_W-1:0] limit_q;
  logic [TMO_W-1:0] cnt_q;

  assign expire = run && at_last(16'(cnt_q), 16'(limit_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (arm) begin
      limit_q <= limit;
      cnt_q   <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/bsr_requester.sv
module bsr_requester #(
  parameter int          WORD_W   = 64,
  parameter int          ADDR_W   = 40,
  parameter int          OP_W     = 8,
  parameter int          TMO_W    = 16,
  parameter logic [7:0]  OP_WRITE = 8'h82,
  parameter logic [7:0]  OP_READ  = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              link_vld,
  output logic              link_data,
  input  logic              resp_vld,
  input  logic              resp_data,
  output logic              done,
  output logic              done_err,
  output logic [WORD_W-1:0] rd_data
);
  import bsr_pkg::*;

  localparam int RSV_W = WORD_W - OP_W - ADDR_W;

  bsr_state_e state_q, state_d;
  logic write_q;
  logic err_q;

  // Named internal events, also used by the checker.
  logic ev_accept;
  logic ev_ack;
  logic ev_timeout;
  logic tx_active;
  logic tx_last;
  logic rx_last;
  logic wd_expire;
  logic [WORD_W-1:0] header;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign ev_accept  = cmd_valid && cmd_ready;
  assign ev_ack     = (state_q == ST_WAIT) && resp_vld;
  assign ev_timeout = (state_q == ST_WAIT) && !resp_vld && wd_expire;
  assign header     = {(cmd_write ? OP_W'(OP_WRITE) : OP_W'(OP_READ)),
                       {RSV_W{1'b0}}, cmd_addr};

  bsr_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ev_accept),
    .first_word  (header),
    .second_word (cmd_wdata),
    .two_words   (cmd_write),
    .ser_vld     (link_vld),
    .ser_bit     (link_data),
    .active      (tx_active),
    .last_bit    (tx_last)
  );

  bsr_rx_deser #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_accept),
    .shift_en (state_q == ST_RECV),
    .bit_in   (resp_data),
    .word     (rd_data),
    .last_bit (rx_last)
  );

  bsr_wait_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (ev_accept),
    .limit  (tmo_limit),
    .run    (state_q == ST_WAIT),
    .expire (wd_expire)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (ev_accept) state_d = ST_SEND;
      ST_SEND: if (tx_last)   state_d = ST_WAIT;
      ST_WAIT: begin
        if (ev_ack)          state_d = write_q ? ST_DONE : ST_RECV;
        else if (ev_timeout) state_d = ST_DONE;
      end
      ST_RECV: if (rx_last)   state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        write_q <= cmd_write;
        err_q   <= 1'b0;
      end else if (ev_timeout) begin
        err_q <= 1'b1;
      end
    end
  end

  assign done     = (state_q == ST_DONE);
  assign done_err = done && err_q;

endmodule

// File: rtl/bsr_requester_chk.sv
module bsr_requester_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic link_vld,
  input logic link_data,
  input logic done,
  input logic done_err,
  input logic tx_active,
  input logic ev_accept,
  input logic ev_timeout
);

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R3
  first_bit_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> link_vld);

  // R4
  marker_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |=> !link_vld);

  // R6
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (!link_data && !link_vld));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R10
  timeout_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (done && done_err));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

endmodule

bind bsr_requester bsr_requester_chk u_chk (.*);

// File: tb/bsr_requester_test.sv
module bsr_requester_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [39:0] cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic [15:0] tmo_limit = '0;
  logic        link_vld, link_data;
  logic        resp_vld = 1'b0;
  logic        resp_data = 1'b0;
  logic        done, done_err;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bsr_requester uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .tmo_limit(tmo_limit), .link_vld(link_vld), .link_data(link_data),
    .resp_vld(resp_vld), .resp_data(resp_data), .done(done),
    .done_err(done_err), .rd_data(rd_data)
  );

  function automatic logic [63:0] exp_header(input bit wr, input logic [39:0] a);
    logic [63:0] h;
    h = {24'h0, a};
    h[63:56] = wr ? 8'h82 : 8'h81;
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One command end to end. to_mode: expect a timeout instead of a reply.
  task automatic run_cmd(input bit wr, input logic [39:0] a, input logic [63:0] d,
                         input logic [15:0] lim, input int dly, input bit to_mode,
                         input logic [63:0] reply);
    logic [63:0] cap0, cap1;
    int nbits, vbad, cnt;
    nbits = wr ? 128 : 64;
    vbad = 0;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1 ready when idle", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; tmo_limit = lim;
    @(posedge clk);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      if (k == 0) begin
        cmd_valid = 1'b0;
        cmd_wdata = ~d;
        cmd_addr = ~a;
      end
      if (k < 64) cap0[k] = link_data; else cap1[k-64] = link_data;
      if (link_vld !== ((k % 64) == 0)) vbad++;
      resp_data = 1'($urandom);
    end
    chk(cap0 === exp_header(wr, a), "R2 R3 R11 header word", cap0, exp_header(wr, a));
    if (wr) chk(cap1 === d, "R5 write data word", cap1, d);
    chk(vbad == 0, "R4 R5 marker placement", 64'(vbad), 64'd0);
    @(negedge clk);
    chk({link_data, link_vld, cmd_ready} === 3'b000, "R6 R1 line idle and busy in wait",
        64'({link_data, link_vld, cmd_ready}), 64'd0);
    if (to_mode) begin
      cnt = 0;
      while (done !== 1'b1 && cnt < 70000) begin
        @(negedge clk);
        resp_data = 1'($urandom);
        cnt++;
      end
      chk(cnt == int'(lim), "R10 timeout latency", 64'(cnt), 64'(lim));
      chk(done_err === 1'b1 && rd_data === 64'd0, "R10 error flag and empty result",
          {rd_data[62:0], done_err}, 64'd1);
    end else begin
      repeat (dly) begin
        @(negedge clk);
        resp_data = 1'($urandom);
      end
      chk(done === 1'b0, "R9 no done before reply", 64'(done), 64'd0);
      resp_vld = 1'b1;
      resp_data = 1'($urandom);
      @(negedge clk);
      resp_vld = 1'b0;
      if (wr) begin
        resp_data = 1'($urandom);
        chk(done === 1'b1, "R7 R9 done after acknowledge", 64'(done), 64'd1);
        chk(done_err === 1'b0 && rd_data === 64'd0, "R7 reply line ignored on write",
            {rd_data[62:0], done_err}, 64'd0);
      end else begin
        resp_data = reply[0];
        for (int b = 1; b < 64; b++) begin
          @(negedge clk);
          resp_data = reply[b];
        end
        @(negedge clk);
        resp_data = 1'b0;
        chk(done === 1'b1 && done_err === 1'b0, "R8 R9 done after last bit",
            64'({done, done_err}), 64'b10);
        chk(rd_data === reply, "R8 read word", rd_data, reply);
      end
    end
    @(negedge clk);
    resp_data = 1'b0;
    chk(done === 1'b0 && cmd_ready === 1'b1, "R9 R1 single done then ready",
        64'({done, cmd_ready}), 64'b01);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk({cmd_ready, link_vld, link_data, done, done_err} === 5'b10000 && rd_data === '0,
        "R1 R6 reset state", 64'({cmd_ready, link_vld, link_data, done, done_err}), 64'b10000);
    rst_n = 1'b1;
    // Directed corners.
    run_cmd(1'b1, 40'hFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'd8, 0, 1'b0, '0);
    run_cmd(1'b0, 40'h12_3456_7807, '0, 16'd8, 7, 1'b0, 64'h8000_0000_0000_0001);
    run_cmd(1'b1, 40'h00_0000_0005, 64'hA5A5_0000_5A5A_FFFF, 16'd5, 0, 1'b1, '0);
    run_cmd(1'b0, 40'h0A_0000_0003, '0, 16'd1, 0, 1'b1, '0);
    run_cmd(1'b0, 40'h00_0000_0000, '0, 16'd1, 0, 1'b0, 64'hDEAD_BEEF_0123_4567);
    run_cmd(1'b1, 40'h55_5555_5555, 64'h0, 16'd0, 300, 1'b0, '0);
    // Random mix.
    n = 24;
    for (int i = 0; i < n; i++) begin
      bit wr, to;
      logic [15:0] lim;
      wr  = 1'($urandom);
      to  = ($urandom % 5) == 0;
      lim = 16'(1 + $urandom % 40);
      run_cmd(wr, {8'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
              lim, int'($urandom % lim), to, {32'($urandom), 32'($urandom)});
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule